// File: doc/BRIEF.md
# Bus Address Breakpoint Interrupt Unit

This block watches the read and write strobes of a 24-bit external address bus. It raises an interrupt when an access of an enabled type hits a programmed breakpoint address. The interrupt leaves on one output line that is shared with a user push-key. Each event gives a single-clock high pulse on that line. Two sticky flags tell software which source fired: the breakpoint, the key, or both in the same cycle.

Software uses a small byte-wide register window to set up the block:
- a control byte with the two break enables and the breakpoint flag,
- three bytes that hold the breakpoint address,
- a status byte that holds the key enable, the key flag, the debounced key level and a configuration jumper level.

When the two break enables and the key enable are all clear, the output enable of the line drops and the line is left to an external pull-up. A small-model input narrows the address compare to the low 16 bits. The key input comes from a debounced source but is asynchronous to the clock, so it is synchronised inside the block.

Top module: `bkpt_irq_unit`

## Requirements
- R1: After reset, the control byte reads 0x00, status bits 1 and 2 read 0, and both `irq_oe` and `irq_out` are 0.
- R2: The breakpoint address bytes sit at offsets 0xC5 (bits 7:0), 0xC6 (bits 15:8) and 0xC7 (bits 23:16) and read back what was written. In the control byte at 0xC4, bit 0 (break on read) and bit 1 (break on write) are read/write, and bits 7:3 read 0. Any unmapped offset reads 0x00.
- R3: The first cycle of a read strobe with control bit 0 set, or of a write strobe with control bit 1 set, raises `irq_out` after the next clock edge when the bus address equals the breakpoint address. An access of a type that is not enabled, or to another address, gives no pulse.
- R4: While `small_model` is 1, only bus address bits 15:0 are compared. While it is 0, all 24 bits are compared.
- R5: `irq_out` is never high on two consecutive cycles. A strobe held for several cycles gives one pulse. A hit in the cycle right after a pulse sets its flag but gives no second pulse.
- R6: Control bit 2 (breakpoint flag) is set on every breakpoint hit. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R7: `irq_oe` is 1 exactly when control bit 0, control bit 1 or status bit 1 (key enable) is 1.
- R8: With status bit 1 set, a rising edge on `ukey_in` sets status bit 2 (key flag) and pulses `irq_out` on the third clock edge after the input changes. With status bit 1 clear, a key edge changes neither the flag nor the line.
- R9: Status bit 3 shows the synchronised key level two clock edges after `ukey_in` changes. Status bit 0 shows `jmp_open`, and bits 7:4 read 0.
- R10: A write to 0xC8 with bit 2 = 0 clears the key flag, and a write with bit 2 = 1 does not set it. Bit 1 of that write sets the key enable.
- R11: A breakpoint hit and a key event in the same cycle give one pulse and set both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| bus_addr | input | 24 | Watched bus address |
| bus_rd_stb | input | 1 | Bus read strobe |
| bus_wr_stb | input | 1 | Bus write strobe |
| small_model | input | 1 | 1 limits the compare to address bits 15:0 |
| jmp_open | input | 1 | Jumper level: 0 when fitted, 1 when open |
| ukey_in | input | 1 | Debounced user key, asynchronous |
| irq_out | output | 1 | Interrupt pulse |
| irq_oe | output | 1 | Output enable of the shared interrupt line |

## Verification
Most wrong internal states show up at the ports within one or two cycles. A wrong compare mask, compare byte or enable decode shows in the first `irq_out` sample after the strobe edge, so the bench sweeps every enable/access/mode combination and every single-bit address mismatch. A lost or wrongly held strobe edge register shows as a missing pulse or a second pulse. A wrong synchroniser depth moves the key pulse by whole cycles, and the bench samples each of them. A flag whose set or clear logic is wrong stays hidden until the next register read, so every event in the bench is followed by a read-back of both flags.

// File: rtl/bkpt_irq_pkg.sv
package bkpt_irq_pkg;
   localparam int unsigned REG_W = 8;

   // register offsets; software depends on these
   localparam logic [7:0] OFS_CTRL  = 8'hC4;
   localparam logic [7:0] OFS_ADDR0 = 8'hC5;
   localparam logic [7:0] OFS_STAT  = 8'hC8;

   // control byte fields
   localparam int unsigned CTL_RD  = 0;
   localparam int unsigned CTL_WR  = 1;
   localparam int unsigned CTL_HIT = 2;

   // status byte fields
   localparam int unsigned STS_JMP = 0;
   localparam int unsigned STS_EN  = 1;
   localparam int unsigned STS_KEY = 2;
   localparam int unsigned STS_LVL = 3;

   typedef struct packed {
      logic brk_rd;
      logic brk_wr;
      logic ukie;
   } irq_cfg_t;
endpackage

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned SMALL_W = 16
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              small_model,
   output logic              match
);
   localparam int unsigned NB   = ADDR_W / 8;
   localparam int unsigned LOWB = SMALL_W / 8;

   if (SMALL_W % 8 != 0 || SMALL_W == 0 || SMALL_W >= ADDR_W) begin : g_bad_small
      $error("bkpt_addr_cmp: SMALL_W must be a non-zero byte multiple below ADDR_W");
   end

   logic [NB-1:0] byte_eq;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign byte_eq[b] = (bus_addr[b*8 +: 8] == bp_addr[b*8 +: 8]);
   end

   logic low_eq, high_eq;
   assign low_eq  = &byte_eq[LOWB-1:0];
   assign high_eq = &byte_eq[NB-1:LOWB];
   assign match   = low_eq & (small_model | high_eq);
endmodule

// File: rtl/bkpt_key_sync.sv
module bkpt_key_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_in,
   output logic key_lvl,
   output logic key_rise
);
   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("bkpt_key_sync: STAGES must be 1 to 4");
   end

   logic [STAGES-1:0] chain;
   logic              lvl_prev;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= key_in;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], key_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= chain[STAGES-1];
   end

   assign key_lvl  = chain[STAGES-1];
   assign key_rise = chain[STAGES-1] & ~lvl_prev;
endmodule

// File: rtl/bkpt_irq_gen.sv
module bkpt_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rd_stb,
   input  logic bus_wr_stb,
   input  logic addr_match,
   input  bkpt_irq_pkg::irq_cfg_t cfg,
   input  logic key_rise,
   output logic bk_hit,
   output logic uk_hit,
   output logic irq_pulse
);
   logic rd_q, wr_q, rd_first, wr_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= bus_rd_stb;
         wr_q <= bus_wr_stb;
      end
   end

   assign rd_first = bus_rd_stb & ~rd_q;
   assign wr_first = bus_wr_stb & ~wr_q;

   assign bk_hit = addr_match & ((rd_first & cfg.brk_rd) | (wr_first & cfg.brk_wr));
   assign uk_hit = key_rise & cfg.ukie;

   // a pulse is always followed by a low cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_pulse <= 1'b0;
      else        irq_pulse <= (bk_hit | uk_hit) & ~irq_pulse;
   end
endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [7:0]        reg_rdata,
   input  logic              bk_hit,
   input  logic              uk_hit,
   input  logic              key_lvl,
   input  logic              jmp_open,
   output logic [ADDR_W-1:0] bp_addr,
   output bkpt_irq_pkg::irq_cfg_t cfg,
   output logic              hbi_flag,
   output logic              uki_flag
);
   import bkpt_irq_pkg::*;

   localparam int unsigned NB = ADDR_W / 8;

   if (ADDR_W % 8 != 0 || NB < 1 || NB > 3) begin : g_bad_width
      $error("bkpt_regfile: ADDR_W must be 8, 16 or 24");
   end

   logic wr_ctrl, wr_stat;
   assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
   assign wr_stat = reg_we && (reg_addr == OFS_STAT);

   logic brk_rd_q, brk_wr_q, ukie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_rd_q <= 1'b0;
         brk_wr_q <= 1'b0;
         ukie_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            brk_rd_q <= reg_wdata[CTL_RD];
            brk_wr_q <= reg_wdata[CTL_WR];
         end
         if (wr_stat) ukie_q <= reg_wdata[STS_EN];
      end
   end

   // sticky flags: an event set wins over a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hbi_flag <= 1'b0;
         uki_flag <= 1'b0;
      end else begin
         if (bk_hit)                            hbi_flag <= 1'b1;
         else if (wr_ctrl && !reg_wdata[CTL_HIT]) hbi_flag <= 1'b0;
         if (uk_hit)                            uki_flag <= 1'b1;
         else if (wr_stat && !reg_wdata[STS_KEY]) uki_flag <= 1'b0;
      end
   end

   logic [7:0] addr_byte [NB];

   for (genvar b = 0; b < NB; b++) begin : g_abyte
      localparam logic [7:0] OFS = OFS_ADDR0 + 8'(b);
      always_ff @(posedge clk) begin
         if (reg_we && reg_addr == OFS) addr_byte[b] <= reg_wdata;
      end
      assign bp_addr[b*8 +: 8] = addr_byte[b];
   end

   assign cfg.brk_rd = brk_rd_q;
   assign cfg.brk_wr = brk_wr_q;
   assign cfg.ukie   = ukie_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_CTRL) begin
         reg_rdata[CTL_RD]  = brk_rd_q;
         reg_rdata[CTL_WR]  = brk_wr_q;
         reg_rdata[CTL_HIT] = hbi_flag;
      end else if (reg_addr == OFS_STAT) begin
         reg_rdata[STS_JMP] = jmp_open;
         reg_rdata[STS_EN]  = ukie_q;
         reg_rdata[STS_KEY] = uki_flag;
         reg_rdata[STS_LVL] = key_lvl;
      end else begin
         for (int b = 0; b < NB; b++) begin
            if (reg_addr == OFS_ADDR0 + 8'(b)) reg_rdata = addr_byte[b];
         end
      end
   end
endmodule

// File: rtl/bkpt_irq_unit.sv
module bkpt_irq_unit #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned SMALL_W     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [7:0]        reg_rdata,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd_stb,
   input  logic              bus_wr_stb,
   input  logic              small_model,
   input  logic              jmp_open,
   input  logic              ukey_in,
   output logic              irq_out,
   output logic              irq_oe
);
   import bkpt_irq_pkg::*;

   logic [ADDR_W-1:0] bp_addr;
   irq_cfg_t          cfg;
   logic              hbi_flag, uki_flag, ukie_en;
   logic              key_lvl, key_rise, addr_match;
   logic              bk_hit, uk_hit, irq_pulse;

   bkpt_regfile #(.ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .bk_hit(bk_hit), .uk_hit(uk_hit), .key_lvl(key_lvl), .jmp_open(jmp_open),
      .bp_addr(bp_addr), .cfg(cfg), .hbi_flag(hbi_flag), .uki_flag(uki_flag)
   );

   bkpt_addr_cmp #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W)) cmp_i (
      .bus_addr(bus_addr), .bp_addr(bp_addr), .small_model(small_model), .match(addr_match)
   );

   bkpt_key_sync #(.STAGES(SYNC_STAGES)) ksync_i (
      .clk(clk), .rst_n(rst_n), .key_in(ukey_in), .key_lvl(key_lvl), .key_rise(key_rise)
   );

   bkpt_irq_gen gen_i (
      .clk(clk), .rst_n(rst_n),
      .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
      .addr_match(addr_match), .cfg(cfg), .key_rise(key_rise),
      .bk_hit(bk_hit), .uk_hit(uk_hit), .irq_pulse(irq_pulse)
   );

   assign ukie_en = cfg.ukie;
   assign irq_oe  = cfg.brk_rd | cfg.brk_wr | cfg.ukie;
   assign irq_out = irq_pulse & irq_oe;
endmodule

// File: rtl/bkpt_irq_chk.sv
module bkpt_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_out,
   input logic       hbi,
   input logic       uki,
   input logic       ukie,
   input logic       reg_we,
   input logic [7:0] reg_addr,
   input logic [7:0] reg_wdata
);
   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |=> !irq_out);

   assert_flag_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (hbi || uki));

   assert_hbi_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hbi) |-> $past(reg_we && reg_addr == 8'hC4 && !reg_wdata[2]));

   assert_uki_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uki) |-> $past(ukie));

   assert_uki_clear_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(uki) |-> $past(reg_we && reg_addr == 8'hC8 && !reg_wdata[2]));
endmodule

bind bkpt_irq_unit bkpt_irq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out),
   .hbi(hbi_flag), .uki(uki_flag), .ukie(ukie_en),
   .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/bkpt_irq_unit_tb.sv
module bkpt_irq_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0, reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_rdata;
   logic [23:0] bus_addr = '0;
   logic        bus_rd_stb = 1'b0, bus_wr_stb = 1'b0;
   logic        small_model = 1'b0, jmp_open = 1'b1, ukey_in = 1'b0;
   logic        irq_out, irq_oe;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   localparam logic [23:0] BP = 24'hA53C96;

   always #4 clk = ~clk;

   bkpt_irq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
      .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb), .small_model(small_model),
      .jmp_open(jmp_open), .ukey_in(ukey_in), .irq_out(irq_out), .irq_oe(irq_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_check(input string req, input logic [7:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      check(req, 32'(reg_rdata), 32'(exp));
   endtask

   // one-cycle access; irq sampled after the first and second edge
   task automatic access(input string req, input bit is_wr, input logic [23:0] a, input bit exp);
      @(negedge clk);
      bus_addr = a; bus_rd_stb = !is_wr; bus_wr_stb = is_wr;
      @(negedge clk);
      check(req, 32'(irq_out), 32'(exp));
      bus_rd_stb = 1'b0; bus_wr_stb = 1'b0;
      @(negedge clk);
      check({req, " tail"}, 32'(irq_out), 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      reg_check("R1 ctrl", 8'hC4, 8'h00);
      reg_check("R1 status", 8'hC8, 8'h01);
      check("R1 oe", 32'(irq_oe), 0);
      check("R1 out", 32'(irq_out), 0);

      // R2 register map
      reg_write(8'hC5, BP[7:0]);
      reg_write(8'hC6, BP[15:8]);
      reg_write(8'hC7, BP[23:16]);
      reg_check("R2 addr lo", 8'hC5, BP[7:0]);
      reg_check("R2 addr mid", 8'hC6, BP[15:8]);
      reg_check("R2 addr hi", 8'hC7, BP[23:16]);
      reg_write(8'hC4, 8'hFB);
      reg_check("R2 ctrl mask", 8'hC4, 8'h03);
      reg_check("R2 unmapped C9", 8'hC9, 8'h00);
      reg_check("R2 unmapped 00", 8'h00, 8'h00);

      // R9 jumper level
      for (int j = 0; j < 2; j++) begin
         jmp_open = j[0];
         reg_check("R9 jumper", 8'hC8, 8'(j));
      end
      jmp_open = 1'b0;

      // R3 R4 R7 sweep: enables x mode x access type x address pattern
      for (int en = 0; en < 4; en++) begin
         for (int sm = 0; sm < 2; sm++) begin
            for (int acc = 0; acc < 2; acc++) begin
               for (int pat = 0; pat < 3; pat++) begin
                  logic [23:0] a;
                  bit hit;
                  reg_write(8'hC4, 8'(en));
                  check("R7 oe", 32'(irq_oe), 32'(en != 0));
                  small_model = sm[0];
                  a = (pat == 0) ? BP : (pat == 1) ? (BP ^ 24'h000008) : (BP ^ 24'h100000);
                  hit = ((acc == 0 && en[0]) || (acc == 1 && en[1])) &&
                        (pat == 0 || (pat == 2 && sm == 1));
                  access("R3 R4 sweep", acc[0], a, hit);
                  reg_check("R6 flag", 8'hC4, 8'(en) | (hit ? 8'h04 : 8'h00));
               end
            end
         end
      end

      // R4 every single-bit miss in both modes
      reg_write(8'hC4, 8'h03);
      for (int i = 0; i < 24; i++) begin
         for (int sm = 0; sm < 2; sm++) begin
            small_model = sm[0];
            access("R4 bit sweep", 1'b0, BP ^ (24'h1 << i), (sm == 1) && (i >= 16));
            reg_write(8'hC4, 8'h03);
         end
      end
      small_model = 1'b0;

      // R6 writing 1 to the flag does not set it
      reg_write(8'hC4, 8'h05);
      reg_check("R6 no set by write", 8'hC4, 8'h01);

      // R5 held strobe gives one pulse
      @(negedge clk);
      bus_addr = BP; bus_rd_stb = 1'b1;
      @(negedge clk);
      check("R5 held first", 32'(irq_out), 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R5 held later", 32'(irq_out), 0);
      end
      bus_rd_stb = 1'b0;

      // R5 back-to-back hits: second one suppressed, flag still set
      reg_write(8'hC4, 8'h03);
      @(negedge clk);
      bus_rd_stb = 1'b1;
      @(negedge clk);
      check("R5 b2b first", 32'(irq_out), 1);
      bus_rd_stb = 1'b0; bus_wr_stb = 1'b1;
      @(negedge clk);
      check("R5 b2b second", 32'(irq_out), 0);
      bus_wr_stb = 1'b0;
      @(negedge clk);
      check("R5 b2b tail", 32'(irq_out), 0);
      reg_check("R6 b2b flag", 8'hC4, 8'h07);

      // R8 key disabled: no flag, no pulse; R9 level still follows
      reg_write(8'hC4, 8'h00);
      reg_write(8'hC8, 8'h00);
      check("R7 all off", 32'(irq_oe), 0);
      ukey_in = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R8 disabled", 32'(irq_out), 0);
      end
      reg_check("R8 R9 disabled status", 8'hC8, 8'h08);
      ukey_in = 1'b0;
      repeat (3) @(negedge clk);

      // R8 key enabled, latency check
      reg_write(8'hC8, 8'h02);
      check("R7 key only", 32'(irq_oe), 1);
      ukey_in = 1'b1;
      @(negedge clk);
      reg_check("R9 level after 1", 8'hC8, 8'h02);
      check("R8 edge1", 32'(irq_out), 0);
      @(negedge clk);
      reg_check("R9 level after 2", 8'hC8, 8'h0A);
      check("R8 edge2", 32'(irq_out), 0);
      @(negedge clk);
      check("R8 edge3", 32'(irq_out), 1);
      @(negedge clk);
      check("R8 edge4", 32'(irq_out), 0);
      reg_check("R8 flag", 8'hC8, 8'h0E);
      ukey_in = 1'b0;
      repeat (3) @(negedge clk);

      // R10 clear and no-set
      reg_write(8'hC8, 8'h02);
      reg_check("R10 cleared", 8'hC8, 8'h02);
      reg_write(8'hC8, 8'h06);
      reg_check("R10 no set", 8'hC8, 8'h02);

      // R11 key event and breakpoint hit in the same cycle
      reg_write(8'hC4, 8'h01);
      ukey_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = BP; bus_rd_stb = 1'b1;
      @(negedge clk);
      check("R11 pulse", 32'(irq_out), 1);
      bus_rd_stb = 1'b0;
      @(negedge clk);
      check("R11 single", 32'(irq_out), 0);
      reg_check("R11 hbi", 8'hC4, 8'h05);
      reg_check("R11 uki", 8'hC8, 8'h0E);
      ukey_in = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule